// File: doc/BRIEF.md
# Bus-Cycle Breakpoint Match Unit

This unit watches every cycle on a processor bus and raises a break interrupt request when that cycle fits a programmed condition. The condition has two parts. The first is an address compare in which chosen bits can be excluded. The second is three two-bit qualifiers, one each for the bus master, the access kind and the transfer direction. A match sets a pending flag. The request output is the pending flag gated by the CPU's current 4-bit interrupt mask level, checked against the fixed break priority of 15. A request that is blocked by the mask is not lost. It stays pending until the mask level drops, and the CPU's acknowledge clears it.

Software programs the unit through a small synchronous register port with three registers: compare address, ignore mask and qualifiers. All three reset to zero, so the unit cannot raise a break until software sets it up.

Top module: `brk_match_unit`

## Requirements
- R1: After reset, all three registers are zero and `brk_req` is low. With zeroed qualifiers, no bus cycle of any kind produces a request.
- R2: An address compares equal when every bit that is clear in the ignore mask equals the corresponding bit of the compare address. A bit that is set in the ignore mask always counts as equal.
- R3: The qualifier register sits at `reg_sel`=2. Bits [1:0] are the master group (`bus_master`: 0=CPU, 1=DMA). Bits [3:2] are the kind group (`bus_data`: 0=instruction fetch, 1=data). Bits [5:4] are the direction group (`bus_write`: 0=read, 1=write). In each group, 01 matches only value 0, 10 matches only value 1, and 11 matches either.
- R4: If any qualifier group is 00, no request is ever produced, even when the address and the other groups match.
- R5: A match is evaluated only in a cycle with `bus_valid` high. The pending flag is registered, so `brk_req` rises one clock after the matching cycle.
- R6: The break priority is 15. `brk_req` is high only while a request is pending and `cpu_imask` is 14 or lower. While `cpu_imask` is 15 the request stays pending, and it appears as soon as the level drops.
- R7: `brk_ack` clears the pending request only in a cycle where `brk_req` is high. An acknowledge while `brk_req` is low has no effect.
- R8: A match while a request is pending does not queue a second request, so a single acknowledge leaves nothing pending. If a match and an acknowledge fall in the same cycle, the match wins and the request stays set.
- R9: Register writes take effect on the next clock. A bus cycle in the same cycle as a write is judged against the old register values. `reg_sel` 0 selects the compare address, 1 selects the ignore mask and 2 selects the qualifiers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 ignore mask, 2 qualifiers |
| reg_wdata | input | ADDR_W | Register write data |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_master | input | 1 | 0 = CPU, 1 = DMA |
| bus_data | input | 1 | 0 = instruction fetch, 1 = data access |
| bus_write | input | 1 | 0 = read, 1 = write |
| cpu_imask | input | 4 | CPU interrupt mask level |
| brk_ack | input | 1 | CPU acknowledge of the break request |
| brk_req | output | 1 | Break interrupt request |

## Verification
A new match and an acknowledge can fall in the same clock. So can a register write and the bus cycle it is meant to govern. The bench drives an acknowledge together with a second matching bus cycle, and expects the request to stay set. It then writes zero qualifiers in the same cycle as a matching bus cycle, and expects that cycle to fire under the old settings. In both cases a behavioural model of pending state, gated by the mask level, is compared with `brk_req` on every clock.

// File: rtl/brk_match_unit.sv
module brk_match_unit #(
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 4,
  parameter int BRK_LEVEL = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_master,
  input  logic              bus_data,
  input  logic              bus_write,
  input  logic [LVL_W-1:0]  cpu_imask,
  input  logic              brk_ack,
  output logic              brk_req
);
  localparam logic [LVL_W-1:0] PRIO = LVL_W'(BRK_LEVEL);

  logic [ADDR_W-1:0] cmp_addr, cmp_mask;
  logic [5:0]        qual;
  logic              pend_q;

  function automatic logic grp_ok(input logic [1:0] sel, input logic opt);
    return (sel == 2'b11) || (sel == 2'b01 && !opt) || (sel == 2'b10 && opt);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_addr <= '0;
      cmp_mask <= '0;
      qual     <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0:    cmp_addr <= reg_wdata;
        2'd1:    cmp_mask <= reg_wdata;
        2'd2:    qual     <= reg_wdata[5:0];
        default: ;
      endcase
    end
  end

  wire addr_hit = ((bus_addr ^ cmp_addr) & ~cmp_mask) == '0;
  wire type_hit = grp_ok(qual[1:0], bus_master) &&
                  grp_ok(qual[3:2], bus_data) &&
                  grp_ok(qual[5:4], bus_write);
  wire hit      = bus_valid && addr_hit && type_hit;
  wire accept   = cpu_imask < PRIO;

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (hit)                pend_q <= 1'b1;
    else if (brk_ack && brk_req) pend_q <= 1'b0;
  end

  assign brk_req = pend_q && accept;
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        cpu_imask,
  input logic              brk_ack,
  input logic              brk_req,
  input logic [ADDR_W-1:0] cmp_addr,
  input logic [ADDR_W-1:0] cmp_mask,
  input logic [5:0]        qual,
  input logic              pend_q
);
  AST_RISE_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(bus_valid)); // R5

  AST_RISE_ADDR_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(((bus_addr ^ cmp_addr) & ~cmp_mask) == '0)); // R2

  AST_ZERO_GROUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && (qual[1:0] == 2'b00 || qual[3:2] == 2'b00 || qual[5:4] == 2'b00))
      |=> !pend_q); // R4

  AST_HOLD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cpu_imask == 4'hF) |=> pend_q); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && brk_ack && !bus_valid) |=> !pend_q); // R7

  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !brk_req) |=> pend_q); // R7

  AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ack && brk_req && bus_valid && qual == 6'h3F && cmp_mask == '1) |=> pend_q); // R8
endmodule

bind brk_match_unit brk_match_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .cpu_imask(cpu_imask), .brk_ack(brk_ack), .brk_req(brk_req),
  .cmp_addr(cmp_addr), .cmp_mask(cmp_mask), .qual(qual), .pend_q(pend_q)
);

// File: tb/test_brk_match_unit.sv
module test_brk_match_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, bus_addr = '0;
  logic bus_valid = 1'b0, bus_master = 1'b0, bus_data = 1'b0, bus_write = 1'b0;
  logic [3:0] cpu_imask = '0;
  logic brk_ack = 1'b0;
  logic brk_req;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  logic [31:0] m_addr, m_mask;
  logic [5:0]  m_q;
  bit          m_pend;

  always #2 clk = ~clk;

  brk_match_unit i_brk_match_unit (.*);

  function automatic bit g_ok(input logic [1:0] s, input logic o);
    case (s)
      2'b01:   return !o;
      2'b10:   return o;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit acc, hit;
    if (!rst_n) begin
      m_addr = '0; m_mask = '0; m_q = '0; m_pend = 0;
    end else begin
      acc = m_pend && (cpu_imask <= 4'd14);
      hit = bus_valid && (((bus_addr ^ m_addr) & ~m_mask) == 0) &&
            g_ok(m_q[1:0], bus_master) && g_ok(m_q[3:2], bus_data) &&
            g_ok(m_q[5:4], bus_write);
      if (hit) m_pend = 1;
      else if (brk_ack && acc) m_pend = 0;
      if (reg_we) begin
        if (reg_sel == 2'd0) m_addr = reg_wdata;
        else if (reg_sel == 2'd1) m_mask = reg_wdata;
        else if (reg_sel == 2'd2) m_q = reg_wdata[5:0];
      end
    end
  end

  task automatic check_req(input bit exp);
    n_chk++;
    if (brk_req !== exp) begin
      n_fail++;
      $display("FAIL %s: brk_req=%0b expected %0b", tag, brk_req, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_req(m_pend && (cpu_imask <= 4'd14));
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic cyc(input logic [31:0] a, input logic m, input logic k, input logic w);
    bus_valid = 1; bus_addr = a; bus_master = m; bus_data = k; bus_write = w;
    tick();
    bus_valid = 0;
  endtask

  task automatic ack();
    brk_ack = 1; tick(); brk_ack = 0;
  endtask

  task automatic done();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run=hung expected=finished");
    done();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; check_req(1'b0);
    for (int t = 0; t < 8; t++) cyc(32'h0, t[0], t[1], t[2]);
    tick(); check_req(1'b0);

    tag = "R2";
    wr(2'd0, 32'h1000_0040); wr(2'd1, 32'h0000_000F); wr(2'd2, 32'h3D);
    cyc(32'h1000_0047, 0, 0, 0);
    tag = "R5"; check_req(1'b1);
    ack(); tick();
    tag = "R2"; cyc(32'h1000_0050, 0, 1, 1); tick(); check_req(1'b0);
    tag = "R5"; bus_addr = 32'h1000_0040; tick(); check_req(1'b0);

    tag = "R3";
    wr(2'd1, 32'h0);
    for (int q = 0; q < 64; q++) begin
      tag = ((q & 3) == 0 || (q & 12) == 0 || (q & 48) == 0) ? "R4" : "R3";
      wr(2'd2, 32'(q));
      for (int t = 0; t < 8; t++) begin
        cyc(32'h1000_0040, t[0], t[1], t[2]);
        ack();
      end
    end

    tag = "R6";
    wr(2'd2, 32'h3F);
    cpu_imask = 4'hF;
    cyc(32'h1000_0040, 1, 1, 1);
    check_req(1'b0);
    repeat (3) tick();
    tag = "R7"; ack(); tick();
    tag = "R6"; cpu_imask = 4'd14; tick(); check_req(1'b1);
    tag = "R7"; ack(); check_req(1'b0);

    tag = "R8";
    cpu_imask = 4'd3;
    cyc(32'h1000_0040, 0, 1, 0);
    cyc(32'h1000_0040, 0, 1, 0);
    ack(); check_req(1'b0); tick();
    cyc(32'h1000_0040, 0, 0, 1);
    brk_ack = 1; cyc(32'h1000_0040, 1, 0, 0); brk_ack = 0;
    check_req(1'b1);
    ack(); check_req(1'b0);

    tag = "R9";
    reg_we = 1; reg_sel = 2'd2; reg_wdata = 32'h0;
    cyc(32'h1000_0040, 0, 0, 0);
    reg_we = 0;
    check_req(1'b1);
    ack();
    cyc(32'h1000_0040, 0, 0, 0); tick(); check_req(1'b0);
    reg_we = 1; reg_sel = 2'd2; reg_wdata = 32'h3F;
    cyc(32'h1000_0040, 0, 0, 0);
    reg_we = 0;
    check_req(1'b0);
    cyc(32'h1000_0040, 0, 0, 0); check_req(1'b1);
    ack();
    repeat (2) tick();
    done();
  end
endmodule